// File: doc/BRIEF.md
# UART auto-baud lock responder

This block is the receive front end of a serial link whose host baud rate is not known in advance. After reset it sits through a fixed start-up window and ignores the RX line. It then waits for a start bit and times the edges of one sync character, ASCII 'U' (0x55). That character alternates its bits, so every bit boundary carries an edge. From the edge timing it derives a bit period in system clocks.

It then confirms the character by sampling the last data bit and the stop bit at mid-bit with the period it has just learned. If the character is confirmed, it freezes that period as the divisor and raises a lock flag. It then sends one acknowledge byte (0x06) back to the host at the learned rate.

Any attempt that fails a timing, range or content test is dropped without trace, and the block waits for the next start bit. Once locked, it keeps the divisor until the next reset. The start-up window length and the accepted divisor range are parameters, all counted in system clock cycles.

Top module: `autobaud_sync_resp`

## Requirements
- R1: While reset is held, and at any time the block is not locked, `tx_o` is 1, `locked_o` is 0 and `divisor_o` reads 0.
- R2: For STARTUP_CYCLES cycles after reset release, the RX line is ignored. A complete 0x55 character sent inside that window produces no lock and no low level on `tx_o`.
- R3: A measurement starts only on a high-to-low transition of RX after the window. A line held low through and after the window produces neither lock nor TX activity.
- R4: The divisor is the sum of the eight edge-to-edge intervals, from the start-bit falling edge to the edge that opens data bit 7, divided by 8 and truncated. For a clean character with a bit period of N cycles, this gives N.
- R5: Let F be the first interval (the start bit). Each later interval must lie within F - floor(F/4) to F + floor(F/4), inclusive. An interval outside that range discards the attempt.
- R6: The attempt is discarded when the first interval exceeds 2*DIV_MAX cycles, or when the derived divisor lies outside DIV_MIN..DIV_MAX (both bounds inclusive).
- R7: The frame is 8 data bits, LSB first, no parity, one stop bit. Lock requires data bit 7 to read 0 about half a divisor after its leading edge, and the stop bit to read 1 about one and a half divisors after that edge. Only 0x55 can pass; any other character is rejected.
- R8: After a discarded attempt the block returns to waiting for a start bit, and a later valid 0x55 locks normally.
- R9: On lock the block sends 0x06 exactly once, framed as: start bit 0, data LSB first, stop bit 1. Each bit lasts exactly `divisor_o` cycles.
- R10: Once locked, `locked_o` stays 1 and `divisor_o` keeps its value until reset. Further RX activity causes no further transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial data from the host, idle high |
| tx_o | output | 1 | Serial data to the host, idle high |
| locked_o | output | 1 | High once the baud rate has been learned |
| divisor_o | output | $clog2(DIV_MAX+1) | Learned bit period in clock cycles, 0 while unlocked |

## Verification
An RX edge reaches the measurement logic two synchroniser cycles late. Every interval is delayed by the same amount, so a character driven with N-cycle bits yields exactly N. Lock and the ACK start bit follow about 1.5 periods after the edge that opens bit 7. The bench therefore waits 11 periods plus 30 cycles after the stop bit before checking the lock flag, the divisor and the captured ACK.

A monitor detects the ACK falling edge on `tx_o` and samples each bit at its mid-point from that edge. Because 0x06 opens with two low bits, the monitor also checks that the first rising edge comes exactly two divisors after the start edge. Rejected attempts are judged at least 300 cycles after the last stimulus, so the 2*DIV_MAX first-interval timeout has always expired by then.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  localparam logic [7:0]  SYNC_BYTE  = 8'h55;
  localparam logic [7:0]  ACK_BYTE   = 8'h06;
  localparam int unsigned EDGE_COUNT = 8;

  typedef enum logic [2:0] {
    ABR_INIT,
    ABR_IDLE,
    ABR_MEAS,
    ABR_BIT7,
    ABR_STOP,
    ABR_LOCK
  } abr_state_e;
endpackage

// File: rtl/abr_rx_front.sv
module abr_rx_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle level is high, so reset to 1 to avoid a false start bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rx_s_o = sync_q[SYNC_STAGES-1];
  assign fall_o = prev_q & ~rx_s_o;
  assign rise_o = ~prev_q & rx_s_o;
endmodule

// File: rtl/abr_period_meter.sv
module abr_period_meter #(
  parameter int unsigned CW    = 18,
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned EDGES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          edge_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [CW-1:0] period_o
);
  localparam int unsigned SH  = $clog2(EDGES);
  localparam int unsigned SW  = CW + SH + 1;
  localparam int unsigned IXW = (SH > 0) ? SH : 1;
  localparam logic [IXW-1:0] LAST_IDX = IXW'(EDGES - 1);

  logic           active_q;
  logic [CW-1:0]  cnt_q, first_q;
  logic [IXW-1:0] idx_q;
  logic [SW-1:0]  sum_q, sum_nxt;
  logic [CW-1:0]  hi, lo;
  logic           in_win;

  always_comb begin
    if (idx_q == '0) begin
      hi = CW'(LIMIT);
      lo = '0;
    end else begin
      hi = first_q + (first_q >> 2);
      lo = first_q - (first_q >> 2);
    end
    in_win  = (cnt_q >= lo) && (cnt_q <= hi);
    sum_nxt = sum_q + SW'(cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      first_q  <= '0;
      idx_q    <= '0;
      sum_q    <= '0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
      period_o <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(1);
        idx_q    <= '0;
        sum_q    <= '0;
      end else if (active_q) begin
        if (edge_i) begin
          if (!in_win) begin
            fail_o   <= 1'b1;
            active_q <= 1'b0;
          end else begin
            if (idx_q == '0) first_q <= cnt_q;
            if (idx_q == LAST_IDX) begin
              done_o   <= 1'b1;
              period_o <= CW'(sum_nxt >> SH);
              active_q <= 1'b0;
            end else begin
              sum_q <= sum_nxt;
              idx_q <= idx_q + 1'b1;
              cnt_q <= CW'(1);
            end
          end
        end else if (cnt_q > hi) begin
          // no edge inside the window: early abort
          fail_o   <= 1'b1;
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/abr_tx_ser.sv
module abr_tx_ser #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o
);
  localparam int unsigned FW = DATA_W + 2;
  localparam int unsigned LW = $clog2(FW + 1);

  logic [FW-1:0]    shf_q;
  logic [LW-1:0]    left_q;
  logic [DIV_W-1:0] bdiv_q, tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q  <= '1;
      left_q <= '0;
      bdiv_q <= '0;
      tcnt_q <= '0;
    end else if (go_i) begin
      shf_q  <= {1'b1, data_i, 1'b0};
      left_q <= LW'(FW);
      bdiv_q <= div_i;
      tcnt_q <= '0;
    end else if (left_q != '0) begin
      if (tcnt_q == bdiv_q - 1'b1) begin
        tcnt_q <= '0;
        shf_q  <= {1'b1, shf_q[FW-1:1]};
        left_q <= left_q - 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign tx_o = shf_q[0];
endmodule

// File: rtl/autobaud_sync_resp.sv
module autobaud_sync_resp
  import autobaud_pkg::*;
#(
  parameter  int unsigned STARTUP_CYCLES = 62_500_000,
  parameter  int unsigned DIV_MIN        = 16,
  parameter  int unsigned DIV_MAX        = 65535,
  parameter  int unsigned SYNC_STAGES    = 2,
  localparam int unsigned DIV_W          = $clog2(DIV_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             locked_o,
  output logic [DIV_W-1:0] divisor_o
);
  localparam int unsigned CW = DIV_W + 2;
  localparam int unsigned IW = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
  localparam logic [IW-1:0] INIT_LAST = IW'(STARTUP_CYCLES - 1);

  abr_state_e       state_q;
  logic [IW-1:0]    init_cnt_q;
  logic [CW-1:0]    smp_cnt_q, per_q;
  logic [DIV_W-1:0] div_q;

  logic          rx_s, rx_fall, rx_rise;
  logic          meas_start, m_done, m_fail;
  logic [CW-1:0] m_period;
  logic          period_ok;
  logic [CW-1:0] b7_mid, stop_mid;
  logic          tx_go;

  abr_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall),
    .rise_o (rx_rise)
  );

  assign meas_start = (state_q == ABR_IDLE) && rx_fall;

  abr_period_meter #(
    .CW    (CW),
    .LIMIT (2 * DIV_MAX),
    .EDGES (EDGE_COUNT)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (meas_start),
    .edge_i   (rx_fall | rx_rise),
    .done_o   (m_done),
    .fail_o   (m_fail),
    .period_o (m_period)
  );

  assign period_ok = (m_period >= CW'(DIV_MIN)) && (m_period <= CW'(DIV_MAX));
  assign b7_mid    = per_q >> 1;
  assign stop_mid  = per_q + (per_q >> 1);
  assign tx_go     = (state_q == ABR_STOP) && (smp_cnt_q == stop_mid) && rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ABR_INIT;
      init_cnt_q <= '0;
      smp_cnt_q  <= '0;
      per_q      <= '0;
      div_q      <= '0;
    end else begin
      unique case (state_q)
        ABR_INIT: begin
          if (init_cnt_q == INIT_LAST) state_q <= ABR_IDLE;
          else init_cnt_q <= init_cnt_q + 1'b1;
        end
        ABR_IDLE: if (rx_fall) state_q <= ABR_MEAS;
        ABR_MEAS: begin
          if (m_fail) begin
            state_q <= ABR_IDLE;
          end else if (m_done) begin
            if (period_ok) begin
              per_q     <= m_period;
              smp_cnt_q <= CW'(1);
              state_q   <= ABR_BIT7;
            end else begin
              state_q <= ABR_IDLE;
            end
          end
        end
        ABR_BIT7: begin
          smp_cnt_q <= smp_cnt_q + 1'b1;
          if (smp_cnt_q == b7_mid)
            state_q <= (rx_s == SYNC_BYTE[7]) ? ABR_STOP : ABR_IDLE;
        end
        ABR_STOP: begin
          smp_cnt_q <= smp_cnt_q + 1'b1;
          if (smp_cnt_q == stop_mid) begin
            if (rx_s) begin
              state_q <= ABR_LOCK;
              div_q   <= per_q[DIV_W-1:0];
            end else begin
              state_q <= ABR_IDLE;
            end
          end
        end
        ABR_LOCK: ;
        default: state_q <= ABR_INIT;
      endcase
    end
  end

  abr_tx_ser #(.DIV_W(DIV_W), .DATA_W(8)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (tx_go),
    .div_i  (per_q[DIV_W-1:0]),
    .data_i (ACK_BYTE),
    .tx_o   (tx_o)
  );

  assign locked_o  = (state_q == ABR_LOCK);
  assign divisor_o = div_q;
endmodule

// File: rtl/autobaud_sync_resp_chk.sv
module autobaud_sync_resp_chk
  import autobaud_pkg::*;
#(
  parameter  int unsigned DIV_MIN = 16,
  parameter  int unsigned DIV_MAX = 65535,
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_o,
  input logic             locked_o,
  input logic [DIV_W-1:0] divisor_o,
  input abr_state_e       state_i
);
  p_div_zero_unlocked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> divisor_o == '0);

  p_tx_idle_unlocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> tx_o);

  p_div_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (divisor_o >= DIV_W'(DIV_MIN) && divisor_o <= DIV_W'(DIV_MAX)));

  p_lock_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(state_i) == ABR_STOP);

  p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  p_div_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(divisor_o));
endmodule

bind autobaud_sync_resp autobaud_sync_resp_chk #(
  .DIV_MIN (DIV_MIN),
  .DIV_MAX (DIV_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_o      (tx_o),
  .locked_o  (locked_o),
  .divisor_o (divisor_o),
  .state_i   (state_q)
);

// File: tb/autobaud_sync_resp_bench.sv
`timescale 1ns/1ps
module autobaud_sync_resp_bench;
  localparam int unsigned P_START = 200;
  localparam int unsigned P_MIN   = 8;
  localparam int unsigned P_MAX   = 64;
  localparam int unsigned DW      = $clog2(P_MAX + 1);
  localparam int          WD_CYCLES = 190000;
  localparam logic [9:0]  ACK_FRAME = 10'h20C; // stop=1, 0x06, start=0

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          tx, locked;
  logic [DW-1:0] div_w;

  always #4 clk = ~clk;

  autobaud_sync_resp #(
    .STARTUP_CYCLES (P_START),
    .DIV_MIN        (P_MIN),
    .DIV_MAX        (P_MAX)
  ) u_autobaud_sync_resp (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .rx_i      (rx),
    .tx_o      (tx),
    .locked_o  (locked),
    .divisor_o (div_w)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 1'b0;

  // TX monitor
  int         mon_div = 16;
  int         mon_pos = 0;
  bit         mon_in = 1'b0;
  logic       mon_prev = 1'b1;
  logic [9:0] mon_bits = '0;
  int         mon_low_run = -1;
  int         frames = 0;
  int         tx_low_total = 0;
  logic [9:0] last_frame = '0;
  int         last_low_run = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_in   = 1'b0;
      mon_prev = 1'b1;
    end else begin
      if (!tx) tx_low_total++;
      if (!mon_in && mon_prev && !tx) begin
        mon_in      = 1'b1;
        mon_pos     = 0;
        mon_low_run = -1;
      end
      if (mon_in) begin
        if (tx && mon_low_run < 0) mon_low_run = mon_pos;
        for (int k = 0; k < 10; k++)
          if (mon_pos == k * mon_div + mon_div / 2) mon_bits[k] = tx;
        if (mon_pos == 9 * mon_div + mon_div / 2) begin
          mon_in       = 1'b0;
          frames++;
          last_frame   = mon_bits;
          last_low_run = mon_low_run;
        end
        mon_pos++;
      end
      mon_prev = tx;
    end
  end

  logic [9:0] lvls;
  int         durs [10];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic rx_lvl);
    @(negedge clk);
    rx = rx_lvl;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic uniform(input logic [7:0] b, input int d);
    lvls = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) durs[i] = d;
  endtask

  task automatic send();
    for (int i = 0; i < 10; i++) begin
      rx = lvls[i];
      tick(durs[i]);
    end
    rx = 1'b1;
  endtask

  task automatic expect_lock(input string req, input int d_exp, input int f0);
    chk(locked == 1'b1, req, "locked", locked, 1);
    chk(int'(div_w) == d_exp, req, "divisor", div_w, d_exp);
    chk(frames - f0 == 1, req, "ack count", frames - f0, 1);
    chk(last_frame == ACK_FRAME, req, "ack frame", last_frame, ACK_FRAME);
    chk(last_low_run == 2 * d_exp, req, "ack low run", last_low_run, 2 * d_exp);
  endtask

  task automatic expect_none(input string req, input int f0, input int l0);
    chk(locked == 1'b0, req, "locked", locked, 0);
    chk(div_w == '0, req, "divisor", div_w, 0);
    chk(frames == f0, req, "ack count", frames - f0, 0);
    chk(tx_low_total == l0, req, "tx low cycles", tx_low_total - l0, 0);
  endtask

  task automatic run_valid(input string req, input int d);
    int f0;
    mon_div = d;
    f0 = frames;
    uniform(8'h55, d);
    send();
    tick(11 * d + 30);
    expect_lock(req, d, f0);
  endtask

  task automatic run_reject(input string req, input int wait_cyc);
    int f0, l0;
    f0 = frames;
    l0 = tx_low_total;
    send();
    tick(wait_cyc);
    expect_none(req, f0, l0);
  endtask

  task automatic fresh();
    do_reset(1'b1);
    tick(P_START + 10);
  endtask

  task automatic run_all();
    int f0, l0;
    // R1: reset state
    @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    tick(2);
    chk(tx == 1'b1, "R1", "tx in reset", tx, 1);
    chk(locked == 1'b0, "R1", "locked in reset", locked, 0);
    chk(div_w == '0, "R1", "divisor in reset", div_w, 0);
    rst_n = 1'b1;

    // R2: character inside the start-up window is ignored
    tick(5);
    f0 = frames;
    l0 = tx_low_total;
    uniform(8'h55, 10);
    send();
    tick(P_START + 300 - 5 - 100);
    expect_none("R2", f0, l0);
    run_valid("R2", 12);

    // R4 R9: sweep every legal divisor
    for (int d = P_MIN; d <= P_MAX; d++) begin
      fresh();
      run_valid("R4", d);
    end

    // R6: divisor range bounds and first-interval limit
    fresh();
    uniform(8'h55, P_MIN - 1);
    run_reject("R6", 300);
    fresh();
    uniform(8'h55, P_MAX + 1);
    run_reject("R6", 300);
    fresh();
    uniform(8'h55, 20);
    durs[0] = 2 * P_MAX + 12;
    run_reject("R6", 300);

    // R5: tolerance window around first interval (F=40, window 30..50)
    fresh();
    uniform(8'h55, 40);
    durs[3] = 50;
    mon_div = (7 * 40 + 50) / 8;
    f0 = frames;
    send();
    tick(11 * 41 + 30);
    expect_lock("R5", (7 * 40 + 50) / 8, f0);
    fresh();
    uniform(8'h55, 40);
    durs[3] = 30;
    mon_div = (7 * 40 + 30) / 8;
    f0 = frames;
    send();
    tick(11 * 38 + 30);
    expect_lock("R5", (7 * 40 + 30) / 8, f0);
    fresh();
    uniform(8'h55, 40);
    durs[3] = 51;
    run_reject("R5", 400);
    fresh();
    uniform(8'h55, 40);
    durs[5] = 29;
    run_reject("R5", 400);

    // R7: content checks
    fresh();
    uniform(8'h41, 20);
    run_reject("R7", 300);
    fresh();
    uniform(8'hD5, 20);
    run_reject("R7", 300);
    fresh();
    uniform(8'h55, 40);
    durs[8] = 10;            // bit 7 ends early, line high at mid-bit
    run_reject("R7", 300);
    fresh();
    uniform(8'h55, 40);
    lvls[9] = 1'b0;          // stop bit low
    run_reject("R7", 300);

    // R8: recovery after a rejected attempt, no reset
    run_valid("R8", 24);

    // R3: line held low is not a start bit
    do_reset(1'b0);
    f0 = frames;
    l0 = tx_low_total;
    tick(P_START + 400);
    expect_none("R3", f0, l0);
    rx = 1'b1;
    tick(50);
    run_valid("R3", 16);

    // R10: locked state holds against new traffic
    fresh();
    run_valid("R10", 20);
    f0 = frames;
    uniform(8'h55, 30);
    send();
    tick(400);
    chk(locked == 1'b1, "R10", "locked held", locked, 1);
    chk(int'(div_w) == 20, "R10", "divisor held", div_w, 20);
    chk(frames == f0, "R10", "no second ack", frames - f0, 0);
  endtask

  initial begin
    fork
      begin
        run_all();
        done_flag = 1'b1;
      end
      begin
        repeat (WD_CYCLES) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1..all actual=%0d expected=%0d", 0, 1);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule